// File: doc/BRIEF.md
# Rotating Register Window Controller

This block sits between an execution pipeline and a physical register file of `NAREG` words. Software sees sixteen logical registers; the controller maps them onto a sliding window of the physical file. The window origin is kept in units of four-register groups, and the logical index is added to four times that origin. All index arithmetic wraps around the end of the physical file. Next to the origin, the block keeps a per-group occupancy mask. Each bit in the mask marks a group as the start of a live call frame.

The pipeline issues one of four window operations, with the program counter and the operands that operation needs. The four operations are a frame allocation on procedure entry, a pre-access frame check, a windowed return and a stack-pointer-move guard. The block updates the window state in the same clock edge and reports any trap on the next cycle. The trap report carries a cause code, the faulting PC and, for spill and fill traps, the previous window origin. A successful return also reports its target PC. Spill and fill handlers, which live elsewhere, load the window state through a direct load port. The controller does not decode instructions or run handlers.

Top module: `wrf_ctrl`

## Requirements
- R1: Reset leaves `wbase` = 0 and `wstart` with only bit 0 set. It also leaves `exc_valid` and `ret_valid` low.
- R2: Logical register r maps to physical entry (`wbase`*4 + r) mod `NAREG`. Reads are combinational. Writes take effect at the clock edge. A read issued after a rotating edge already uses the new origin.
- R3: When `st_we` is high, `wbase` and `wstart` take `st_wbase` and `st_wstart` at the edge. Any operation presented in that cycle is ignored.
- R4: Frame allocation (`op_kind`=0) is illegal when `op_src` > 3, or when the mode is not (`ps_woe`=1 and `ps_excm`=0). An illegal allocation gives `exc_code` 1 with `exc_pc` = `op_pc`, and leaves `wbase` and `wstart` unchanged.
- R5: A legal allocation writes logical register (`ps_callinc`*4 + `op_src`) with logical register `op_src` minus `op_imm`*8, using the old mapping. It then advances `wbase` by `ps_callinc` and sets the `wstart` bit of the new origin.
- R6: The frame check (`op_kind`=1) does nothing in two cases: when the mode is wrong, or when no `wstart` bit is set at origin+n for n = 1..`op_wlim`.
- R7: Otherwise the check takes the smallest such n and advances `wbase` by n. It leaves `wstart` unchanged and reports `exc_owb` = old origin and `exc_pc` = `op_pc`. Let m be the group where the bit was found. The code is 3 (spill-4) if bit m+1 is set, else 4 (spill-8) if bit m+2 is set, else 5 (spill-12).
- R8: The return (`op_kind`=2) reads n from bits 31:30 of logical register 0. It takes m as the nearest set `wstart` bit among origin-1, -2 and -3, or 0 if none is set. The return is illegal (code 1, state unchanged) when n = 0, when m is nonzero and differs from n, or when the mode is wrong.
- R9: A legal return moves `wbase` back by n. If the new origin's `wstart` bit is set, the return clears the old origin's bit and raises `ret_valid`. Its `ret_pc` is `op_pc`[31:30] joined with logical register 0 bits 29:0.
- R10: If the new origin's bit is clear, the return still rotates but leaves `wstart` unchanged. It reports `exc_owb` = old origin and code 6, 7 or 8 (fill-4, -8, -12) for n = 1, 2 or 3.
- R11: The stack-pointer guard (`op_kind`=3) gives code 2 (alloca) when none of the `wstart` bits at origin-1, -2 and -3 is set. Otherwise it has no effect.
- R12: `exc_*` and `ret_*` are valid exactly in the cycle after the operation edge. `exc_valid` and `ret_valid` are never high together.
- R13: The port write `wr_en` is ignored in any cycle in which `op_valid` or `st_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Window operation present this cycle |
| op_kind | input | 2 | 0 allocate, 1 check, 2 return, 3 stack-pointer guard |
| op_pc | input | XLEN | PC of the operation |
| op_src | input | 4 | Allocation source register index |
| op_imm | input | IMMW | Allocation frame size in 8-byte units |
| op_wlim | input | 2 | Highest group distance the check probes |
| ps_woe | input | 1 | Window traps enabled |
| ps_excm | input | 1 | Exception mode active |
| ps_callinc | input | 2 | Rotation amount of the pending call |
| st_we | input | 1 | Load window state |
| st_wbase | input | WBW | Origin to load |
| st_wstart | input | NG | Occupancy mask to load |
| rd_addr | input | 4 | Logical read index |
| rd_data | output | XLEN | Logical read data |
| wr_en | input | 1 | Logical write enable |
| wr_addr | input | 4 | Logical write index |
| wr_data | input | XLEN | Logical write data |
| wbase | output | WBW | Current window origin |
| wstart | output | NG | Current occupancy mask |
| exc_valid | output | 1 | Trap report valid |
| exc_code | output | 4 | Trap cause code |
| exc_pc | output | XLEN | PC of the trapping operation |
| exc_owb | output | WBW | Old origin for spill and fill traps |
| ret_valid | output | 1 | Return completed without trap |
| ret_pc | output | XLEN | Return target |

## Verification
The bench tries the check, return and guard operations against every occupancy mask at every origin of a 32-entry file. For the check, it also tries every probe limit. This separates the nearest-frame search from a farthest-frame search, and separates the spill-4, -8 and -12 classes. The return is also swept over every call size, so the legal, size-mismatch, clean-return and fill cases all arise with the origin wrapping in both directions. Allocation is run at every origin with every rotation amount and source index. Reading back through the rotated window shows both the computed value and the mapping change. Separate directed cycles show that loads and operations mask the write port.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    typedef enum logic [1:0] {
        OP_ALLOC = 2'd0,
        OP_CHECK = 2'd1,
        OP_RET   = 2'd2,
        OP_SPGRD = 2'd3
    } wrf_op_e;

    typedef enum logic [3:0] {
        EXC_NONE    = 4'd0,
        EXC_ILLEGAL = 4'd1,
        EXC_ALLOCA  = 4'd2,
        EXC_SPILL4  = 4'd3,
        EXC_SPILL8  = 4'd4,
        EXC_SPILL12 = 4'd5,
        EXC_FILL4   = 4'd6,
        EXC_FILL8   = 4'd7,
        EXC_FILL12  = 4'd8
    } wrf_exc_e;

endpackage

// File: rtl/wrf_regfile.sv
module wrf_regfile #(
    parameter int NAREG = 64,
    parameter int XLEN  = 32,
    parameter int NRD   = 3,
    parameter int NWR   = 2,
    localparam int NG   = NAREG / 4,
    localparam int WBW  = $clog2(NG)
) (
    input  logic                           clk,
    input  logic [WBW-1:0]                 wbase,
    input  logic [NRD-1:0][3:0]            rd_log,
    output logic [NRD-1:0][XLEN-1:0]       rd_data,
    input  logic [NWR-1:0]                 wr_en,
    input  logic [NWR-1:0][3:0]            wr_log,
    input  logic [NWR-1:0][XLEN-1:0]       wr_data
);
    localparam int PW = WBW + 2;

    logic [XLEN-1:0] mem_q [NAREG];
    logic [XLEN-1:0] mem_d [NAREG];
    logic [NWR-1:0][PW-1:0] wr_phys;

    // Logical to physical: origin*4 + index, wrapped by the PW-bit sum.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [PW-1:0] phys;
        assign phys       = {wbase, 2'b00} + PW'(rd_log[g]);
        assign rd_data[g] = mem_q[phys];
    end

    for (genvar g = 0; g < NWR; g++) begin : g_wr
        assign wr_phys[g] = {wbase, 2'b00} + PW'(wr_log[g]);
    end

    // Port 0 is applied last and therefore wins on a shared entry.
    always_comb begin
        mem_d = mem_q;
        for (int k = NWR - 1; k >= 0; k--) begin
            if (wr_en[k]) begin
                mem_d[wr_phys[k]] = wr_data[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/wrf_scan.sv
module wrf_scan #(
    parameter int NAREG = 64,
    localparam int NG   = NAREG / 4,
    localparam int WBW  = $clog2(NG)
) (
    input  logic [WBW-1:0] wbase,
    input  logic [NG-1:0]  wstart,
    input  logic [1:0]     wlim,
    output logic           fwd_hit,
    output logic [1:0]     fwd_n,
    output logic [1:0]     fwd_cls,
    output logic [1:0]     bwd_m
);
    logic [WBW-1:0] m_grp;

    always_comb begin
        fwd_hit = 1'b0;
        fwd_n   = 2'd0;
        // Descending scan: the nearest set group is assigned last.
        for (int k = 3; k >= 1; k--) begin
            if (k <= int'(wlim) && wstart[wbase + WBW'(k)]) begin
                fwd_hit = 1'b1;
                fwd_n   = 2'(k);
            end
        end

        m_grp = wbase + WBW'(fwd_n);
        if (wstart[m_grp + WBW'(1)]) begin
            fwd_cls = 2'd0;
        end else if (wstart[m_grp + WBW'(2)]) begin
            fwd_cls = 2'd1;
        end else begin
            fwd_cls = 2'd2;
        end

        bwd_m = 2'd0;
        for (int k = 3; k >= 1; k--) begin
            if (wstart[wbase - WBW'(k)]) begin
                bwd_m = 2'(k);
            end
        end
    end

endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
    import wrf_pkg::*;
#(
    parameter int NAREG = 64,
    parameter int XLEN  = 32,
    parameter int IMMW  = 12,
    localparam int NG   = NAREG / 4,
    localparam int WBW  = $clog2(NG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [XLEN-1:0]  op_pc,
    input  logic [3:0]       op_src,
    input  logic [IMMW-1:0]  op_imm,
    input  logic [1:0]       op_wlim,
    input  logic             ps_woe,
    input  logic             ps_excm,
    input  logic [1:0]       ps_callinc,
    input  logic             st_we,
    input  logic [WBW-1:0]   st_wbase,
    input  logic [NG-1:0]    st_wstart,
    input  logic [3:0]       rd_addr,
    output logic [XLEN-1:0]  rd_data,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [XLEN-1:0]  wr_data,
    output logic [WBW-1:0]   wbase,
    output logic [NG-1:0]    wstart,
    output logic             exc_valid,
    output logic [3:0]       exc_code,
    output logic [XLEN-1:0]  exc_pc,
    output logic [WBW-1:0]   exc_owb,
    output logic             ret_valid,
    output logic [XLEN-1:0]  ret_pc
);
    typedef struct packed {
        logic [WBW-1:0]  wb;
        logic [NG-1:0]   ws;
        logic            exc_v;
        wrf_exc_e        exc_code;
        logic [XLEN-1:0] exc_pc;
        logic [WBW-1:0]  exc_owb;
        logic            ret_v;
        logic [XLEN-1:0] ret_pc;
    } wrf_state_t;

    wrf_state_t q, d;

    // Register file: read port 0 external, 1 allocation source, 2 logical a0.
    logic [2:0][3:0]      rf_rd_log;
    logic [2:0][XLEN-1:0] rf_rd_data;
    logic [1:0]           rf_wr_en;
    logic [1:0][3:0]      rf_wr_log;
    logic [1:0][XLEN-1:0] rf_wr_data;

    logic            alloc_we;
    logic [3:0]      alloc_log;
    logic [XLEN-1:0] alloc_val;
    logic            port_we;

    logic       fwd_hit;
    logic [1:0] fwd_n, fwd_cls, bwd_m;

    assign rf_rd_log  = {4'd0, op_src, rd_addr};
    assign port_we    = wr_en & ~op_valid & ~st_we;
    assign rf_wr_en   = {port_we, alloc_we};
    assign rf_wr_log  = {wr_addr, alloc_log};
    assign rf_wr_data = {wr_data, alloc_val};

    wrf_regfile #(.NAREG(NAREG), .XLEN(XLEN), .NRD(3), .NWR(2)) u_rf (
        .clk     (clk),
        .wbase   (q.wb),
        .rd_log  (rf_rd_log),
        .rd_data (rf_rd_data),
        .wr_en   (rf_wr_en),
        .wr_log  (rf_wr_log),
        .wr_data (rf_wr_data)
    );

    wrf_scan #(.NAREG(NAREG)) u_scan (
        .wbase   (q.wb),
        .wstart  (q.ws),
        .wlim    (op_wlim),
        .fwd_hit (fwd_hit),
        .fwd_n   (fwd_n),
        .fwd_cls (fwd_cls),
        .bwd_m   (bwd_m)
    );

    logic           mode_ok;
    logic [1:0]     ret_n;
    logic [WBW-1:0] new_wb;

    assign mode_ok = ps_woe & ~ps_excm;
    assign ret_n   = rf_rd_data[2][XLEN-1 -: 2];

    always_comb begin
        d          = q;
        d.exc_v    = 1'b0;
        d.exc_code = EXC_NONE;
        d.exc_pc   = '0;
        d.exc_owb  = '0;
        d.ret_v    = 1'b0;
        d.ret_pc   = '0;
        alloc_we   = 1'b0;
        alloc_log  = {ps_callinc, op_src[1:0]};
        alloc_val  = rf_rd_data[1] - (XLEN'(op_imm) << 3);
        new_wb     = q.wb;

        if (st_we) begin
            d.wb = st_wbase;
            d.ws = st_wstart;
        end else if (op_valid) begin
            unique case (wrf_op_e'(op_kind))
                OP_ALLOC: begin
                    if (op_src > 4'd3 || !mode_ok) begin
                        d.exc_v    = 1'b1;
                        d.exc_code = EXC_ILLEGAL;
                        d.exc_pc   = op_pc;
                    end else begin
                        alloc_we      = 1'b1;
                        new_wb        = q.wb + WBW'(ps_callinc);
                        d.wb          = new_wb;
                        d.ws[new_wb]  = 1'b1;
                    end
                end
                OP_CHECK: begin
                    if (mode_ok && fwd_hit) begin
                        d.wb      = q.wb + WBW'(fwd_n);
                        d.exc_v   = 1'b1;
                        d.exc_pc  = op_pc;
                        d.exc_owb = q.wb;
                        unique case (fwd_cls)
                            2'd0:    d.exc_code = EXC_SPILL4;
                            2'd1:    d.exc_code = EXC_SPILL8;
                            default: d.exc_code = EXC_SPILL12;
                        endcase
                    end
                end
                OP_RET: begin
                    if (ret_n == 2'd0 || (bwd_m != 2'd0 && bwd_m != ret_n) || !mode_ok) begin
                        d.exc_v    = 1'b1;
                        d.exc_code = EXC_ILLEGAL;
                        d.exc_pc   = op_pc;
                    end else begin
                        new_wb = q.wb - WBW'(ret_n);
                        d.wb   = new_wb;
                        if (q.ws[new_wb]) begin
                            d.ws[q.wb] = 1'b0;
                            d.ret_v    = 1'b1;
                            d.ret_pc   = {op_pc[XLEN-1 -: 2], rf_rd_data[2][XLEN-3:0]};
                        end else begin
                            d.exc_v   = 1'b1;
                            d.exc_pc  = op_pc;
                            d.exc_owb = q.wb;
                            unique case (ret_n)
                                2'd1:    d.exc_code = EXC_FILL4;
                                2'd2:    d.exc_code = EXC_FILL8;
                                default: d.exc_code = EXC_FILL12;
                            endcase
                        end
                    end
                end
                default: begin
                    if (bwd_m == 2'd0) begin
                        d.exc_v    = 1'b1;
                        d.exc_code = EXC_ALLOCA;
                        d.exc_pc   = op_pc;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ws <= NG'(1);
        end else begin
            q <= d;
        end
    end

    assign rd_data   = rf_rd_data[0];
    assign wbase     = q.wb;
    assign wstart    = q.ws;
    assign exc_valid = q.exc_v;
    assign exc_code  = q.exc_code;
    assign exc_pc    = q.exc_pc;
    assign exc_owb   = q.exc_owb;
    assign ret_valid = q.ret_v;
    assign ret_pc    = q.ret_pc;

endmodule

// File: rtl/wrf_ctrl_chk.sv
module wrf_ctrl_chk #(
    parameter int NAREG = 64,
    parameter int XLEN  = 32,
    localparam int NG   = NAREG / 4,
    localparam int WBW  = $clog2(NG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [1:0]      op_kind,
    input logic [XLEN-1:0] op_pc,
    input logic            st_we,
    input logic [WBW-1:0]  wbase,
    input logic [NG-1:0]   wstart,
    input logic            exc_valid,
    input logic [3:0]      exc_code,
    input logic [XLEN-1:0] exc_pc,
    input logic [WBW-1:0]  exc_owb,
    input logic            ret_valid,
    input logic [XLEN-1:0] ret_pc
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_valid, ret_valid}));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(op_valid) && !$past(st_we)) |-> ($stable(wbase) && $stable(wstart)));

    p_excpc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && exc_valid) |-> (exc_pc == $past(op_pc)));

    p_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && exc_valid && exc_code == 4'd1) |-> ($stable(wbase) && $stable(wstart)));

    p_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_valid && !st_we && op_kind == 2'd0) && !exc_valid) |-> wstart[wbase]);

    p_spill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && exc_valid && exc_code >= 4'd3 && exc_code <= 4'd5)
        |-> (wbase != $past(wbase) && $stable(wstart) && exc_owb == $past(wbase)));

    p_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ret_valid) |-> (ret_pc[XLEN-1 -: 2] == $past(op_pc[XLEN-1 -: 2])
                                  && wstart[wbase] && !wstart[$past(wbase)]));

    p_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && exc_valid && exc_code >= 4'd6)
        |-> ($stable(wstart) && exc_owb == $past(wbase) && !wstart[wbase]));

    p_alloca_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && exc_valid && exc_code == 4'd2) |-> ($stable(wbase) && $stable(wstart)));

endmodule

bind wrf_ctrl wrf_ctrl_chk #(.NAREG(NAREG), .XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .op_pc     (op_pc),
    .st_we     (st_we),
    .wbase     (wbase),
    .wstart    (wstart),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .exc_pc    (exc_pc),
    .exc_owb   (exc_owb),
    .ret_valid (ret_valid),
    .ret_pc    (ret_pc)
);

// File: tb/wrf_ctrl_tb.sv
module wrf_ctrl_tb;
    localparam int NAREG = 32;
    localparam int XLEN  = 32;
    localparam int IMMW  = 12;
    localparam int NG    = NAREG / 4;
    localparam int WBW   = $clog2(NG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] op_kind = '0;
    logic [XLEN-1:0] op_pc = '0;
    logic [3:0] op_src = '0;
    logic [IMMW-1:0] op_imm = '0;
    logic [1:0] op_wlim = '0;
    logic ps_woe = 1'b1, ps_excm = 1'b0;
    logic [1:0] ps_callinc = '0;
    logic st_we = 1'b0;
    logic [WBW-1:0] st_wbase = '0;
    logic [NG-1:0] st_wstart = '0;
    logic [3:0] rd_addr = '0;
    logic [XLEN-1:0] rd_data;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [XLEN-1:0] wr_data = '0;
    logic [WBW-1:0] wbase;
    logic [NG-1:0] wstart;
    logic exc_valid;
    logic [3:0] exc_code;
    logic [XLEN-1:0] exc_pc;
    logic [WBW-1:0] exc_owb;
    logic ret_valid;
    logic [XLEN-1:0] ret_pc;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wrf_ctrl #(.NAREG(NAREG), .XLEN(XLEN), .IMMW(IMMW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_pc(op_pc),
        .op_src(op_src), .op_imm(op_imm), .op_wlim(op_wlim), .ps_woe(ps_woe),
        .ps_excm(ps_excm), .ps_callinc(ps_callinc), .st_we(st_we), .st_wbase(st_wbase),
        .st_wstart(st_wstart), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wbase(wbase), .wstart(wstart),
        .exc_valid(exc_valid), .exc_code(exc_code), .exc_pc(exc_pc), .exc_owb(exc_owb),
        .ret_valid(ret_valid), .ret_pc(ret_pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int bit_at(input int ws, input int g);
        return (ws >> (((g % NG) + NG) % NG)) & 1;
    endfunction

    task automatic load(input int wb, input int ws);
        st_we = 1'b1; st_wbase = WBW'(wb); st_wstart = NG'(ws);
        @(negedge clk);
        st_we = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        rd_addr = 4'(a);
        #1 v = rd_data;
    endtask

    task automatic op(input int kind, input logic [31:0] pc, input int src, input int imm,
                      input int w, input bit woe, input bit excm, input int ci);
        op_valid = 1'b1; op_kind = 2'(kind); op_pc = pc; op_src = 4'(src);
        op_imm = IMMW'(imm); op_wlim = 2'(w); ps_woe = woe; ps_excm = excm;
        ps_callinc = 2'(ci);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    logic [31:0] v;
    logic [31:0] shadow [NAREG];

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wbase", 32'(wbase), 0);
        chk("R1 wstart", 32'(wstart), 1);
        chk("R1 exc_valid", 32'(exc_valid), 0);
        chk("R1 ret_valid", 32'(ret_valid), 0);

        // R2 mapping with wrap: write through every origin, read back through every origin
        for (int wb = 0; wb < NG; wb++) begin
            load(wb, 1);
            for (int r = 0; r < 16; r++) begin
                logic [31:0] val;
                val = 32'hA500_0000 + 32'(wb * 977 + r * 31);
                wr(r, val);
                shadow[(wb * 4 + r) % NAREG] = val;
            end
        end
        for (int wb = 0; wb < NG; wb++) begin
            load(wb, 1);
            chk("R3 wbase load", 32'(wbase), 32'(wb));
            for (int r = 0; r < 16; r++) begin
                rd(r, v);
                chk("R2 mapped read", v, shadow[(wb * 4 + r) % NAREG]);
            end
        end

        // R13 port write masked by an operation and by a state load
        load(2, 6);
        wr(5, 32'h1111_2222);
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'hDEAD_0001;
        op(3, 32'h100, 0, 0, 0, 1, 0, 0);
        wr_en = 1'b0;
        chk("R11 guard no trap", 32'(exc_valid), 0);
        rd(5, v);
        chk("R13 write masked by op", v, 32'h1111_2222);
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'hDEAD_0002;
        load(2, 6);
        wr_en = 1'b0;
        rd(5, v);
        chk("R13 write masked by load", v, 32'h1111_2222);

        // R3 operation ignored while loading
        st_we = 1'b1; st_wbase = 3'd4; st_wstart = 8'h10;
        op(0, 32'h200, 0, 1, 0, 1, 0, 1);
        st_we = 1'b0;
        chk("R3 load wins wbase", 32'(wbase), 4);
        chk("R3 load wins wstart", 32'(wstart), 32'h10);
        chk("R3 op dropped", 32'(exc_valid), 0);

        // R5 legal allocation over all origins, rotations and sources
        for (int wb = 0; wb < NG; wb++)
            for (int ci = 0; ci < 4; ci++)
                for (int s = 0; s < 4; s++) begin
                    int imm;
                    logic [31:0] base;
                    imm = (wb * 5 + ci * 3 + s) % 9 + 1;
                    base = 32'h0004_0000 + 32'(wb * 64 + ci * 16 + s);
                    load(wb, 1 << wb);
                    wr(s, base);
                    op(0, 32'h300, s, imm, 0, 1, 0, ci);
                    chk("R5 alloc wbase", 32'(wbase), 32'((wb + ci) % NG));
                    chk("R5 alloc wstart", 32'(wstart), 32'((1 << wb) | (1 << ((wb + ci) % NG))));
                    chk("R5 alloc no trap", 32'(exc_valid), 0);
                    rd(s, v);
                    chk("R2 R5 read after rotation", v, base - 32'(imm * 8));
                end

        // R4 illegal allocation: source index and mode
        for (int s = 4; s < 16; s++) begin
            load(3, 8);
            op(0, 32'h400 + 32'(s), s, 1, 0, 1, 0, 1);
            chk("R4 illegal src code", 32'(exc_code), 1);
            chk("R4 illegal src pc", exc_pc, 32'h400 + 32'(s));
            chk("R4 illegal src wbase", 32'(wbase), 3);
            chk("R4 illegal src wstart", 32'(wstart), 8);
        end
        for (int md = 0; md < 3; md++) begin
            load(3, 8);
            op(0, 32'h500, 1, 1, 0, md == 1, md != 0, 2);
            chk("R4 illegal mode code", 32'(exc_code), 1);
            chk("R4 illegal mode wbase", 32'(wbase), 3);
            @(negedge clk);
            chk("R12 trap lasts one cycle", 32'(exc_valid), 0);
        end

        // R6 R7 check sweep
        for (int wb = 0; wb < NG; wb++)
            for (int ws = 0; ws < (1 << NG); ws++)
                for (int w = 0; w < 4; w++) begin
                    int n, code;
                    n = 0;
                    for (int k = w; k >= 1; k--) if (bit_at(ws, wb + k) == 1) n = k;
                    load(wb, ws);
                    op(1, 32'h6000 + 32'(ws), 0, 0, w, 1, 0, 0);
                    if (n == 0) begin
                        chk("R6 check no trap", 32'(exc_valid), 0);
                        chk("R6 check wbase", 32'(wbase), 32'(wb));
                    end else begin
                        code = bit_at(ws, wb + n + 1) == 1 ? 3 : (bit_at(ws, wb + n + 2) == 1 ? 4 : 5);
                        chk("R7 spill code", 32'(exc_code), 32'(code));
                        chk("R7 spill wbase", 32'(wbase), 32'((wb + n) % NG));
                        chk("R7 spill owb", 32'(exc_owb), 32'(wb));
                        chk("R7 spill pc", exc_pc, 32'h6000 + 32'(ws));
                        chk("R7 spill wstart", 32'(wstart), 32'(ws));
                    end
                end
        for (int md = 0; md < 3; md++) begin
            load(0, 255);
            op(1, 32'h700, 0, 0, 3, md == 1, md != 0, 0);
            chk("R6 check mode off", 32'(exc_valid), 0);
            chk("R6 check mode wbase", 32'(wbase), 0);
        end

        // R8 R9 R10 return sweep
        for (int wb = 0; wb < NG; wb++)
            for (int ws = 0; ws < (1 << NG); ws++)
                for (int n = 0; n < 4; n++) begin
                    int m, nwb;
                    logic [31:0] a0, pc;
                    m = 0;
                    for (int k = 3; k >= 1; k--) if (bit_at(ws, wb - k) == 1) m = k;
                    a0 = (32'(n) << 30) | (32'h0123_4567 + 32'(ws * 8 + wb));
                    pc = (32'(wb) << 29) | 32'h40;
                    load(wb, ws);
                    wr(0, a0);
                    op(2, pc, 0, 0, 0, 1, 0, 0);
                    nwb = ((wb - n) % NG + NG) % NG;
                    if (n == 0 || (m != 0 && m != n)) begin
                        chk("R8 ret illegal code", 32'(exc_code), 1);
                        chk("R8 ret illegal wbase", 32'(wbase), 32'(wb));
                        chk("R8 ret illegal wstart", 32'(wstart), 32'(ws));
                    end else if (bit_at(ws, nwb) == 1) begin
                        chk("R9 ret valid", 32'(ret_valid), 1);
                        chk("R9 ret pc", ret_pc, (pc & 32'hC000_0000) | (a0 & 32'h3FFF_FFFF));
                        chk("R9 ret wbase", 32'(wbase), 32'(nwb));
                        chk("R9 ret wstart", 32'(wstart), 32'(ws & ~(1 << wb)));
                    end else begin
                        chk("R10 fill code", 32'(exc_code), 32'(5 + n));
                        chk("R10 fill wbase", 32'(wbase), 32'(nwb));
                        chk("R10 fill owb", 32'(exc_owb), 32'(wb));
                        chk("R10 fill wstart", 32'(wstart), 32'(ws));
                        chk("R10 fill no ret", 32'(ret_valid), 0);
                    end
                end
        load(4, 8'h18);
        wr(0, 32'h4000_0000);
        op(2, 32'h800, 0, 0, 0, 1, 1, 0);
        chk("R8 ret mode illegal", 32'(exc_code), 1);
        chk("R8 ret mode wbase", 32'(wbase), 4);

        // R11 guard sweep
        for (int wb = 0; wb < NG; wb++)
            for (int ws = 0; ws < (1 << NG); ws++) begin
                bit none;
                none = bit_at(ws, wb - 1) == 0 && bit_at(ws, wb - 2) == 0 && bit_at(ws, wb - 3) == 0;
                load(wb, ws);
                op(3, 32'h900, 0, 0, 0, 1, 0, 0);
                chk("R11 guard code", 32'(exc_code), none ? 2 : 0);
                chk("R11 guard wbase", 32'(wbase), 32'(wb));
            end

        done = 1'b1;
        finish_run();
    end
endmodule